// File: doc/BRIEF.md
# Eight-Level Masked Interrupt Priority Controller

This block arbitrates among a set of maskable interrupt sources and one non-maskable interrupt (NMI) on behalf of a processor core. Each maskable source has an enable bit, a pending flag and a programmable 3-bit priority. A source occurrence is latched as pending only while its enable bit is set. Among the pending sources, the block selects the one with the highest programmed level. Sources that share that level are resolved by a fixed order in which the lower source index wins.

The winner is compared with a 3-bit mask level held in the block. It is taken only when its level is strictly above the mask, and only in a cycle where the core signals that the current instruction has completed. On acceptance the block does four things: it emits a one-cycle accept pulse with a vector number, loads the mask with the accepted level, clears the trace bit, and clears the winner's pending flag.

An NMI is detected on its rising edge and held until it is taken. It ignores the enable bits and the mask, beats every maskable source, and forces the mask to 7. The core can write the mask and the trace bit back, for example when it returns from a handler.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `mask_lvl` is 7, `trace_bit` is 0, `pending` is all zeros and `accept` is 0.
- R2: Pending bit i (`pending[i]`) is set on the edge after a cycle with `src_event[i]`=1 only if `src_en[i]` was 1 in that cycle. An event with the enable at 0 leaves the bit at 0.
- R3: Source i's priority is `src_prio[3*i+2:3*i]`. The pending source with the greatest value is chosen, and the pending bits of the other sources stay set.
- R4: When several pending sources share the greatest priority, the one with the lowest index is chosen.
- R5: A chosen maskable source is accepted only if its priority is strictly greater than `mask_lvl`. If it is equal or lower, there is no accept and the source stays pending.
- R6: Acceptance happens only on an edge where `insn_done` is 1. `accept` is 1 for the cycle that follows that edge.
- R7: On acceptance of maskable source i, `accept_vec` is VEC_BASE+i (default 16+i), `mask_lvl` becomes that source's priority, and `pending[i]` clears.
- R8: Every acceptance, maskable or NMI, sets `trace_bit` to 0.
- R9: A rising edge on `nmi_in` is latched until it is taken. It ignores the enables and the mask and wins over every maskable source. When taken, `accept_vec` is NMI_VEC (default 7) and `mask_lvl` becomes 7. Holding `nmi_in` high does not raise it again.
- R10: `restore_we`=1 loads `mask_lvl` from `restore_mask` and `trace_bit` from `restore_trace` on the next edge. If an acceptance happens on the same edge, the acceptance values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NUM_SRC | One-cycle occurrence strobes, one per source |
| src_en | input | NUM_SRC | Per-source enable bits |
| src_prio | input | 3*NUM_SRC | Packed 3-bit priority per source |
| nmi_in | input | 1 | Non-maskable request, edge detected |
| insn_done | input | 1 | Current instruction completes this cycle |
| restore_we | input | 1 | Load mask and trace bit from the core |
| restore_mask | input | 3 | Mask value to restore |
| restore_trace | input | 1 | Trace value to restore |
| accept | output | 1 | One-cycle acceptance pulse |
| accept_vec | output | VEC_W | Vector number of the accepted interrupt |
| mask_lvl | output | 3 | Current mask level |
| trace_bit | output | 1 | Current trace bit |
| pending | output | NUM_SRC | Latched maskable requests |

## Verification
The hardest situations to reach are a winner whose level exactly equals the mask, and a tie between sources at the same level. Every acceptance raises the mask, so after the first acceptance nothing at or below that level can be taken. The bench therefore uses the restore port to place the mask exactly at, and just below, a pending level. This shows in turn the refused equal case, the lowest-index tie winner, and the later acceptance of the tie loser. An NMI edge is also raised while a level-7 maskable source is pending, and `nmi_in` is held high afterwards to show that a level alone does not raise the NMI again.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_MAX = '1;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_st_t;

    nmi_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = nmi_in;
        st_d.pend = (st_q.pend & ~ack) | (nmi_in & ~st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_mask_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] prio_flat,
    output logic                     any,
    output logic [IDX_W-1:0]         win_idx,
    output lvl_t                     win_lvl
);
    lvl_t prio_arr [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign prio_arr[g] = prio_flat[g*LVL_W +: LVL_W];
    end

    // Scan from the highest index down; ">=" lets a lower index take a tie.
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!any || prio_arr[i] >= win_lvl)) begin
                any     = 1'b1;
                win_lvl = prio_arr[i];
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_event,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC*LVL_W-1:0] src_prio,
    input  logic                     nmi_in,
    input  logic                     insn_done,
    input  logic                     restore_we,
    input  logic [LVL_W-1:0]         restore_mask,
    input  logic                     restore_trace,
    output logic                     accept,
    output logic [VEC_W-1:0]         accept_vec,
    output logic [LVL_W-1:0]         mask_lvl,
    output logic                     trace_bit,
    output logic [NUM_SRC-1:0]       pending
);
    localparam int IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        lvl_t               mask;
        logic               trace;
        logic [NUM_SRC-1:0] pend;
        logic               acc;
        logic [VEC_W-1:0]   vec;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic             nmi_pend;
    logic             take_nmi;
    logic             take_irq;
    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;

    irq_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_in (nmi_in),
        .ack    (take_nmi),
        .pend   (nmi_pend)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req       (st_q.pend),
        .prio_flat (src_prio),
        .any       (win_any),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    assign take_nmi = insn_done & nmi_pend;
    assign take_irq = insn_done & ~nmi_pend & win_any & (win_lvl > st_q.mask);

    always_comb begin
        logic [NUM_SRC-1:0] clr;
        st_d     = st_q;
        st_d.acc = 1'b0;
        clr      = '0;
        if (restore_we) begin
            st_d.mask  = restore_mask;
            st_d.trace = restore_trace;
        end
        if (take_nmi) begin
            st_d.acc   = 1'b1;
            st_d.vec   = VEC_W'(NMI_VEC);
            st_d.mask  = LVL_MAX;
            st_d.trace = 1'b0;
        end else if (take_irq) begin
            st_d.acc     = 1'b1;
            st_d.vec     = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
            st_d.mask    = win_lvl;
            st_d.trace   = 1'b0;
            clr[win_idx] = 1'b1;
        end
        st_d.pend = (st_q.pend & ~clr) | (src_event & src_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= LVL_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept     = st_q.acc;
    assign accept_vec = st_q.vec;
    assign mask_lvl   = st_q.mask;
    assign trace_bit  = st_q.trace;
    assign pending    = st_q.pend;
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               insn_done,
    input logic               accept,
    input logic [VEC_W-1:0]   accept_vec,
    input logic [2:0]         mask_lvl,
    input logic               trace_bit,
    input logic [NUM_SRC-1:0] pending
);
    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(insn_done)); // R6

    AST_TRACE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !trace_bit); // R8

    AST_NMI_MASK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && accept_vec == VEC_W'(NMI_VEC)) |-> mask_lvl == 3'd7); // R9

    AST_MASK_STRICT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && accept_vec != VEC_W'(NMI_VEC)) |-> mask_lvl > $past(mask_lvl)); // R5

    AST_PEND_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pending) & ~pending)) |-> accept); // R7
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_done  (insn_done),
    .accept     (accept),
    .accept_vec (accept_vec),
    .mask_lvl   (mask_lvl),
    .trace_bit  (trace_bit),
    .pending    (pending)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_event = '0;
    logic [N-1:0]  src_en = '1;
    logic [N*3-1:0] src_prio = '0;
    logic          nmi_in = 1'b0;
    logic          insn_done = 1'b0;
    logic          restore_we = 1'b0;
    logic [2:0]    restore_mask = '0;
    logic          restore_trace = 1'b0;
    logic          accept;
    logic [7:0]    accept_vec;
    logic [2:0]    mask_lvl;
    logic          trace_bit;
    logic [N-1:0]  pending;

    int checks = 0;
    int failures = 0;

    logic       cap_acc;
    logic [7:0] cap_vec;

    always #10 clk = ~clk;

    irq_mask_ctrl u_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .src_event(src_event), .src_en(src_en),
        .src_prio(src_prio), .nmi_in(nmi_in), .insn_done(insn_done),
        .restore_we(restore_we), .restore_mask(restore_mask),
        .restore_trace(restore_trace), .accept(accept), .accept_vec(accept_vec),
        .mask_lvl(mask_lvl), .trace_bit(trace_bit), .pending(pending)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(input int idx, input int lvl);
        src_prio[idx*3 +: 3] = 3'(lvl);
    endtask

    task automatic pulse_event(input int idx);
        @(negedge clk) src_event = N'(1) << idx;
        @(negedge clk) src_event = '0;
    endtask

    task automatic restore(input int m, input bit t);
        @(negedge clk);
        restore_we = 1'b1; restore_mask = 3'(m); restore_trace = t;
        @(negedge clk) restore_we = 1'b0;
    endtask

    task automatic do_insn();
        @(negedge clk) insn_done = 1'b1;
        @(posedge clk); #1;
        cap_acc = accept; cap_vec = accept_vec;
        @(negedge clk) insn_done = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(mask_lvl == 3'd7, "R1 mask in reset", mask_lvl, 7);
        chk(accept == 1'b0 && trace_bit == 1'b0, "R1 accept/trace in reset", {accept, trace_bit}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk(mask_lvl == 3'd7, "R1 mask after reset", mask_lvl, 7);
        chk(pending == '0, "R1 pending after reset", pending, 0);
    endtask

    task automatic t_disabled();
        src_en[3] = 1'b0;
        pulse_event(3);
        chk(pending == '0, "R2 disabled event not latched", pending, 0);
        src_en[3] = 1'b1;
    endtask

    task automatic t_highest();
        restore(0, 1'b0);
        set_prio(1, 3); set_prio(5, 6);
        pulse_event(1); pulse_event(5);
        chk(pending == 8'h22, "R2 enabled events latched", pending, 8'h22);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk(accept == 1'b0, "R6 no accept without insn_done", accept, 0);
        end
        do_insn();
        chk(cap_acc == 1'b1, "R6 accept after insn_done", cap_acc, 1);
        chk(cap_vec == 8'd21, "R3 highest priority vector", cap_vec, 21);
        chk(mask_lvl == 3'd6, "R7 mask takes priority", mask_lvl, 6);
        chk(pending == 8'h02, "R3 lower source stays pending", pending, 8'h02);
        @(posedge clk); #1;
        chk(accept == 1'b0, "R6 accept is one cycle", accept, 0);
    endtask

    task automatic t_mask();
        set_prio(2, 6);
        pulse_event(2);
        do_insn();
        chk(cap_acc == 1'b0, "R5 equal level refused", cap_acc, 0);
        chk(pending == 8'h06, "R5 refused source stays pending", pending, 8'h06);
        restore(5, 1'b0);
        do_insn();
        chk(cap_acc == 1'b1 && cap_vec == 8'd18, "R5 above mask accepted", cap_vec, 18);
        chk(mask_lvl == 3'd6, "R7 mask after accept", mask_lvl, 6);
        do_insn();
        chk(cap_acc == 1'b0, "R5 lower level refused", cap_acc, 0);
    endtask

    task automatic t_tie();
        set_prio(0, 3);
        pulse_event(0);
        restore(0, 1'b0);
        do_insn();
        chk(cap_acc == 1'b1 && cap_vec == 8'd16, "R4 lowest index wins tie", cap_vec, 16);
        chk(pending == 8'h02, "R4 tie loser pending", pending, 8'h02);
        do_insn();
        chk(cap_acc == 1'b0, "R5 tie loser equals mask", cap_acc, 0);
        restore(2, 1'b0);
        do_insn();
        chk(cap_acc == 1'b1 && cap_vec == 8'd17, "R4 tie loser taken later", cap_vec, 17);
        chk(pending == 8'h00, "R7 pending cleared", pending, 0);
    endtask

    task automatic t_nmi();
        set_prio(7, 7);
        pulse_event(7);
        restore(0, 1'b1);
        chk(mask_lvl == 3'd0 && trace_bit == 1'b1, "R10 restore loads mask/trace", {mask_lvl, trace_bit}, 1);
        @(negedge clk) nmi_in = 1'b1;
        do_insn();
        chk(cap_acc == 1'b1 && cap_vec == 8'd7, "R9 NMI beats maskable", cap_vec, 7);
        chk(mask_lvl == 3'd7, "R9 NMI forces mask 7", mask_lvl, 7);
        chk(trace_bit == 1'b0, "R8 trace cleared", trace_bit, 0);
        chk(pending == 8'h80, "R9 maskable still pending", pending, 8'h80);
        do_insn();
        chk(cap_acc == 1'b0, "R9 held NMI level no retrigger", cap_acc, 0);
        restore(0, 1'b0);
        do_insn();
        chk(cap_acc == 1'b1 && cap_vec == 8'd23, "R7 maskable after NMI", cap_vec, 23);
        @(negedge clk) nmi_in = 1'b0;
        restore(7, 1'b0);
        @(negedge clk) nmi_in = 1'b1;
        @(negedge clk) nmi_in = 1'b0;
        do_insn();
        chk(cap_acc == 1'b1 && cap_vec == 8'd7, "R9 NMI ignores mask 7", cap_vec, 7);
    endtask

    task automatic t_restore_vs_accept();
        restore(0, 1'b0);
        set_prio(4, 4);
        pulse_event(4);
        @(negedge clk);
        insn_done = 1'b1; restore_we = 1'b1; restore_mask = 3'd1; restore_trace = 1'b1;
        @(posedge clk); #1;
        chk(accept == 1'b1 && accept_vec == 8'd20, "R10 accept with restore", accept_vec, 20);
        chk(mask_lvl == 3'd4 && trace_bit == 1'b0, "R10 accept wins over restore", {mask_lvl, trace_bit}, 8);
        @(negedge clk);
        insn_done = 1'b0; restore_we = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_highest();
        t_mask();
        t_tie();
        t_nmi();
        t_restore_vs_accept();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule